// File: doc/BRIEF.md
# Lockstep RGB Pixel Serializer

This block turns a stream of character cells into three colour pixel streams that never drift against one another. The master clock is divided by a parameter (six by default, so 24 MHz gives a 4 MHz dot rate), and a one-clock strobe marks each dot slot. Each cell carries an 8-bit pattern and a 3-bit colour enable. A single shifter walks through the pattern. Each channel's pixel is the current pattern bit gated by that channel's enable, and all three channels are loaded into one shared output register on the same clock edge.

A line-active input frames each line. The dot divider restarts when that input rises, so the first pixel always appears exactly one dot period after the window opens, whatever the divider's phase was before. Cells are taken over a valid/ready handshake, one per eight dots. If no cell is offered at the slot, the cell is shown black and an underrun pulse is raised. While the window is closed, every colour output is held low.

Top module: `rgb_cell_serializer`

## Requirements
- R1: While line_active is high, dot_stb is high for exactly one clock in every six. Counting the clock edge that first samples line_active high as edge 0, dot_stb is high in the cycles that follow edges 5, 11, 17 and so on.
- R2: Pixel k of a line (k = 0, 1, ...) appears on the outputs at edge 6(k+1) and holds for exactly six clocks. This applies equally to the first and the last pixel of a line.
- R3: The pattern byte is sent most significant bit first. For example, 0x42 yields the pixels 0,1,0,0,0,0,1,0.
- R4: The attribute bits are the channel enables: bit 0 enables red, bit 1 green and bit 2 blue. Each channel shows the pattern bit ANDed with its enable.
- R5: The red, green and blue outputs change only on the edge that follows a dot_stb cycle, or on the edge that closes the window. They therefore always change together.
- R6: On any clock edge that samples line_active low, all three colour outputs go low in the following cycle and stay low while the window is closed.
- R7: cell_ready is high only during a dot_stb cycle while line_active is high, and only at the slot of the first pixel of a cell. A cell is accepted on that edge when cell_valid is high. Cell slots fall at pixels 0, 8, 16 and so on of a line.
- R8: Changes to cell_pattern, cell_attr or cell_valid outside a cell_ready cycle have no effect on the pixels being shown.
- R9: If cell_valid is low at a cell slot, the cell's eight pixels are black on all channels and underrun is high for the one clock after that slot's edge.
- R10: During and right after reset, the colour outputs, cell_ready and underrun are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_active | input | 1 | High for the visible part of a line |
| cell_valid | input | 1 | A cell is offered on cell_pattern and cell_attr |
| cell_pattern | input | 8 | Eight pixel bits of the cell, MSB shown first |
| cell_attr | input | 3 | Channel enables {blue, green, red} |
| cell_ready | output | 1 | The offered cell is taken on this clock edge |
| dot_stb | output | 1 | One-clock strobe per dot period |
| pix_r | output | 1 | Red pixel |
| pix_g | output | 1 | Green pixel |
| pix_b | output | 1 | Blue pixel |
| underrun | output | 1 | One-clock pulse when no cell was offered at a slot |

## Verification
The hardest case to reach from the ports is a line that opens at an arbitrary divider phase, or one that closes partway through a cell. Both must leave no stretched or shifted pixel on the next line. The stimulus varies the idle gaps between lines so that each line rises at a different divider phase. It aborts one line in the middle of a cell and then checks that the following line restarts cleanly on a cell boundary. While a cell is being shown, the bench drives deliberately wrong pattern, attribute and valid values, and puts the true next cell on the inputs only half a cell later, so any sampling outside the slot shows up as a pixel error.

// File: rtl/rgbser_pkg.sv
package rgbser_pkg;

    // channel positions within the colour vector
    localparam int CH_RED   = 0;
    localparam int CH_GREEN = 1;
    localparam int CH_BLUE  = 2;

    typedef struct packed {
        logic act;       // line_active as seen on the previous edge
        logic underrun;  // one-clock underrun pulse
    } top_st_t;

endpackage

// File: rtl/rgbser_dot_div.sv
module rgbser_dot_div #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic dot_en
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    assign dot_en = (st_q.cnt == CW'(DIV - 1));

    always_comb begin
        st_d = st_q;
        if (restart || dot_en) st_d.cnt = '0;
        else                   st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rgbser_cell_shift.sv
module rgbser_cell_shift #(
    parameter int W   = 8,
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dot_en,
    input  logic           active,
    input  logic           cell_valid,
    input  logic [W-1:0]   cell_pattern,
    input  logic [NCH-1:0] cell_attr,
    output logic           cell_ready,
    output logic           underrun_ev,
    output logic           pix_bit,
    output logic           pix_on,
    output logic [NCH-1:0] pix_attr
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic [W-1:0]   sh;
        logic [NCH-1:0] attr;
        logic [IW-1:0]  idx;
        logic           have;
    } st_t;

    st_t  st_d, st_q;
    logic slot;

    assign slot        = active && dot_en && (st_q.idx == '0);
    assign cell_ready  = slot;
    assign underrun_ev = slot && !cell_valid;

    // at a slot the new cell is shown at once, otherwise the held one
    always_comb begin
        if (slot) begin
            pix_bit  = cell_pattern[W-1];
            pix_on   = cell_valid;
            pix_attr = cell_attr;
        end else begin
            pix_bit  = st_q.sh[W-1];
            pix_on   = st_q.have;
            pix_attr = st_q.attr;
        end
    end

    always_comb begin
        st_d = st_q;
        if (!active) begin
            st_d.idx  = '0;
            st_d.have = 1'b0;
        end else if (dot_en) begin
            st_d.idx = (st_q.idx == IW'(W - 1)) ? '0 : st_q.idx + 1'b1;
            if (slot) begin
                st_d.sh   = cell_pattern << 1;
                st_d.attr = cell_attr;
                st_d.have = cell_valid;
            end else begin
                st_d.sh = st_q.sh << 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rgbser_chan_out.sv
module rgbser_chan_out #(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dot_en,
    input  logic           active,
    input  logic           line_active,
    input  logic           pix_bit,
    input  logic           pix_on,
    input  logic [NCH-1:0] pix_attr,
    output logic [NCH-1:0] pix
);
    typedef struct packed {
        logic [NCH-1:0] rgb;
    } st_t;

    st_t            st_d, st_q;
    logic [NCH-1:0] lit;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        assign lit[ch] = pix_on & pix_bit & pix_attr[ch];
    end

    always_comb begin
        st_d = st_q;
        if (!line_active)          st_d.rgb = '0;
        else if (active && dot_en) st_d.rgb = lit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pix = st_q.rgb;
endmodule

// File: rtl/rgb_cell_serializer.sv
module rgb_cell_serializer
    import rgbser_pkg::*;
#(
    parameter int DIV = 6,
    parameter int W   = 8,
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           line_active,
    input  logic           cell_valid,
    input  logic [W-1:0]   cell_pattern,
    input  logic [NCH-1:0] cell_attr,
    output logic           cell_ready,
    output logic           dot_stb,
    output logic           pix_r,
    output logic           pix_g,
    output logic           pix_b,
    output logic           underrun
);
    top_st_t        st_d, st_q;
    logic           dot_en, restart, active, underrun_ev;
    logic           pix_bit, pix_on;
    logic [NCH-1:0] pix_attr, pix;

    assign restart = line_active && !st_q.act;
    assign active  = line_active && st_q.act;

    rgbser_dot_div #(.DIV(DIV)) div_i (
        .clk(clk), .rst_n(rst_n), .restart(restart), .dot_en(dot_en)
    );

    rgbser_cell_shift #(.W(W), .NCH(NCH)) shift_i (
        .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .active(active),
        .cell_valid(cell_valid), .cell_pattern(cell_pattern),
        .cell_attr(cell_attr), .cell_ready(cell_ready),
        .underrun_ev(underrun_ev), .pix_bit(pix_bit), .pix_on(pix_on),
        .pix_attr(pix_attr)
    );

    rgbser_chan_out #(.NCH(NCH)) out_i (
        .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .active(active),
        .line_active(line_active), .pix_bit(pix_bit), .pix_on(pix_on),
        .pix_attr(pix_attr), .pix(pix)
    );

    always_comb begin
        st_d          = st_q;
        st_d.act      = line_active;
        st_d.underrun = underrun_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dot_stb  = dot_en;
    assign underrun = st_q.underrun;
    assign pix_r    = pix[CH_RED];
    assign pix_g    = pix[CH_GREEN];
    assign pix_b    = pix[CH_BLUE];
endmodule

// File: rtl/rgbser_chk.sv
module rgbser_chk (
    input logic clk,
    input logic rst_n,
    input logic line_active,
    input logic cell_valid,
    input logic cell_ready,
    input logic dot_stb,
    input logic pix_r,
    input logic pix_g,
    input logic pix_b,
    input logic underrun
);
    logic [2:0] rgb;
    assign rgb = {pix_b, pix_g, pix_r};

    a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        dot_stb |=> !dot_stb);

    a_r5_common_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (rgb != $past(rgb)) |-> ($past(dot_stb) || !$past(line_active)));

    a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(line_active) |-> (rgb == 3'b000));

    a_r7_ready_slot: assert property (@(posedge clk) disable iff (!rst_n)
        cell_ready |-> (dot_stb && line_active));

    a_r9_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> $past(cell_ready && !cell_valid));
endmodule

bind rgb_cell_serializer rgbser_chk chk_i (
    .clk(clk), .rst_n(rst_n), .line_active(line_active),
    .cell_valid(cell_valid), .cell_ready(cell_ready), .dot_stb(dot_stb),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .underrun(underrun)
);

// File: tb/rgb_cell_serializer_tb_top.sv
module rgb_cell_serializer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;
    // {valid, attr[2:0] = {b,g,r}, pattern[7:0]}
    localparam logic [11:0] VEC [NV] = '{
        12'hF42, 12'h9FF, 12'hAF0, 12'h7FF, 12'hC0F,
        12'hDA5, 12'hF01, 12'hF80, 12'hB3C, 12'hE01
    };

    logic       clk = 1'b0, rst_n = 1'b0, line_active = 1'b0;
    logic       cell_valid = 1'b0;
    logic [7:0] cell_pattern = '0;
    logic [2:0] cell_attr = '0;
    logic       cell_ready, dot_stb, pix_r, pix_g, pix_b, underrun;

    int n_chk = 0, n_bad = 0, vi = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rgb_cell_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .line_active(line_active),
        .cell_valid(cell_valid), .cell_pattern(cell_pattern),
        .cell_attr(cell_attr), .cell_ready(cell_ready), .dot_stb(dot_stb),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .underrun(underrun)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_pix(logic [11:0] v, int k);
        return v[11] ? ({3{v[7-k]}} & v[10:8]) : 3'b000;
    endfunction

    task automatic present(int i);
        cell_valid   = VEC[i % NV][11];
        cell_attr    = VEC[i % NV][10:8];
        cell_pattern = VEC[i % NV][7:0];
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            tick();
            chk("R6 idle pixels", {pix_b, pix_g, pix_r}, 3'b000);
            chk("R7 no ready when idle", cell_ready, 1'b0);
        end
    endtask

    task automatic run_line(int ncells);
        int npx = ncells * 8;
        int base = vi;
        line_active = 1'b1;
        for (int c = 0; c <= 6 * npx + 5; c++) begin
            logic [2:0] ep;
            int p;
            tick();
            p = c / 6 - 1;
            ep = (c >= 6) ? exp_pix(VEC[base + p / 8], p % 8) : 3'b000;
            chk("R2 R3 R4 R5 R8 pixel", {pix_b, pix_g, pix_r}, ep);
            chk("R1 strobe", dot_stb, (c % 6) == 5);
            chk("R7 ready", cell_ready, (c % 6 == 5) && ((((c + 1) / 6) - 1) % 8 == 0));
            chk("R9 underrun", underrun,
                (c >= 6) && (c % 6 == 0) && (p % 8 == 0) && !VEC[base + p / 8][11]);
            if (c >= 6 && c % 6 == 0 && p % 8 == 0) begin
                vi++;
                // R8: wrong values while a cell is on screen
                cell_valid   = 1'b1;
                cell_attr    = ~VEC[(vi - 1) % NV][10:8];
                cell_pattern = ~VEC[(vi - 1) % NV][7:0];
            end
            if (c >= 6 && c % 6 == 0 && p % 8 == 4) present(vi);
        end
        line_active = 1'b0;
        tick();
        chk("R2 R6 last pixel closed", {pix_b, pix_g, pix_r}, 3'b000);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired (all requirements)");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cell_valid = 1'b1;
        cell_pattern = 8'hFF;
        cell_attr = 3'b111;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset pixels", {pix_b, pix_g, pix_r}, 3'b000);
        chk("R10 reset ready", cell_ready, 1'b0);
        chk("R10 reset underrun", underrun, 1'b0);
        rst_n = 1'b1;
        idle(15);

        present(0);
        run_line(4);   // cells 0..3, last one an underrun (R9)
        idle(7);
        run_line(3);   // cells 4..6, ends on 0x01 (R2 last pixel)
        idle(13);

        // line closed mid-cell: outputs drop on the next edge (R6)
        cell_valid = 1'b1;
        cell_attr = 3'b111;
        cell_pattern = 8'hFF;
        line_active = 1'b1;
        for (int c = 0; c <= 20; c++) tick();
        chk("R2 abort pixel on", {pix_b, pix_g, pix_r}, 3'b111);
        line_active = 1'b0;
        tick();
        chk("R6 abort dark", {pix_b, pix_g, pix_r}, 3'b000);
        present(vi);
        idle(20);

        run_line(3);   // cells 7..9, restart on cell boundary after abort
        idle(5);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule